// File: doc/BRIEF.md
# Non-Maskable Trap Sequencer

This block decides when a processor core leaves its instruction stream for a trap handler. There are two sources. The first is an external trap pin, which is asynchronous to the core clock. The second is a synchronous debug request. Neither source can be masked, and both take precedence over ordinary interrupt service. The core signals each completed instruction, including any wait states, with a strobe. The block waits for that strobe before it vectors, so the instruction in progress always finishes.

When a trap is taken, the block pulses a vector-load strobe with the handler address. It also stores a return address in its program-interrupt register. The stored value depends on the length of the instruction that just finished: after a two-cycle instruction it is the next address, and after a one-cycle instruction it is the address after that one. Once a trap is in service, the block ignores further traps until the core issues a trap-return strobe.

User traps take over the acknowledge and 4-bit status pins. Debug traps leave those pins showing the interrupt state that the core reports.

Top module: `trap_seq`

## Requirements
- R1: In reset, and on the first cycle after reset, `vec_load`, `vec_addr`, `pi_out`, `ack_out` and `stat_out` are all zero.
- R2: `trap_pin` passes through a 2-stage synchronizer, and only its rising edge counts. If the pin is first sampled high at clock edge k while `insn_done` is high, `vec_load` is high for exactly one cycle after edge k+2. A pin held high yields only one trap.
- R3: No trap is taken at an edge where `insn_done` is low. A pending trap is taken at the first edge where `insn_done` is high.
- R4: A user trap loads `vec_addr` = USER_VEC (default 0x46). From the vectoring edge until the trap-return edge, it drives `ack_out`=1 and `stat_out`=USER_CODE (default 4'hB).
- R5: At the vectoring edge, `pi_out` gets `pc_next` when `insn_two_cyc`=1, and `pc_next`+1 (modulo 2^AW) when `insn_two_cyc`=0. At other times `pi_out` keeps its value.
- R6: A trap is taken even while the core is in interrupt service (`irq_ack_in`=1), and it overwrites `pi_out`.
- R7: While a trap is in service, pin rising edges and debug requests are discarded. They cause no vector, and nothing is left pending after the return.
- R8: `trap_ret` ends trap service and re-enables trap acceptance. `trap_ret` has no effect when no trap is in service.
- R9: A rising edge of `dbg_req` (sampled with no synchronizer) is taken at that edge if `insn_done` is high. It loads `vec_addr` = DBG_VEC (default 0x0002) and does not take over `ack_out` or `stat_out`.
- R10: When both sources are pending at the vectoring edge, the user trap wins, and the debug request is dropped.
- R11: Whenever no user trap is in service, `ack_out` and `stat_out` show `irq_ack_in` and `irq_stat_in` from the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_pin | input | 1 | Asynchronous external trap request |
| dbg_req | input | 1 | Synchronous debug trap request, edge-sensitive |
| insn_done | input | 1 | Current instruction (with wait states) completes this cycle |
| insn_two_cyc | input | 1 | Completing instruction is a two-cycle instruction |
| pc_next | input | AW | Address of the instruction after the completing one |
| trap_ret | input | 1 | Return from trap handler |
| irq_ack_in | input | 1 | Interrupt acknowledge state from the core |
| irq_stat_in | input | SW | Interrupt source code from the core |
| vec_load | output | 1 | One-cycle strobe: load `vec_addr` into the PC |
| vec_addr | output | AW | Trap handler address |
| pi_out | output | AW | Saved return address |
| ack_out | output | 1 | Acknowledge pin |
| stat_out | output | SW | 4-bit status pins |

## Verification
The bench builds the block with its default values: AW=16, SW=4, a 2-stage synchronizer, USER_VEC=0x46, DBG_VEC=0x0002 and USER_CODE=0xB. With those values the exact pin-to-vector latency is checked, and the program-counter wraparound case of the return address is reachable. Because the two vector addresses differ, every vectoring event shows which source won. Debug requests and pin edges are also placed inside trap service, on cycles where `insn_done` is low, and in the same cycle as each other.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_USER = 2'd1,
    SRC_DBG  = 2'd2
  } trap_src_e;
endpackage

// File: rtl/trap_sync.sv
module trap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  localparam int CW = STAGES + 1;
  logic [CW-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CW-2:0], async_in};
  end

  // rising edge seen at the output of the last synchronizer stage
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/trap_arb.sv
module trap_arb
  import trap_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      user_rise,
  input  logic      dbg_req,
  input  logic      insn_done,
  input  logic      in_trap,
  output logic      take,
  output trap_src_e take_src
);
  logic dbg_q, dbg_rise;
  logic user_p, dbg_p;
  logic user_any, dbg_any;

  assign dbg_rise = dbg_req & ~dbg_q;
  assign user_any = user_p | user_rise;
  assign dbg_any  = dbg_p  | dbg_rise;
  assign take     = ~in_trap & insn_done & (user_any | dbg_any);
  assign take_src = user_any ? SRC_USER : (dbg_any ? SRC_DBG : SRC_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q  <= 1'b0;
      user_p <= 1'b0;
      dbg_p  <= 1'b0;
    end else begin
      dbg_q <= dbg_req;
      if (in_trap || take) begin
        user_p <= 1'b0;
        dbg_p  <= 1'b0;
      end else begin
        user_p <= user_any;
        dbg_p  <= dbg_any;
      end
    end
  end
endmodule

// File: rtl/trap_ctx.sv
module trap_ctx
  import trap_seq_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          SW        = 4,
  parameter logic [AW-1:0] USER_VEC = 'h46,
  parameter logic [AW-1:0] DBG_VEC  = 'h02,
  parameter logic [SW-1:0] USER_CODE = 'hB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  trap_src_e     take_src,
  input  logic          insn_two_cyc,
  input  logic [AW-1:0] pc_next,
  input  logic          trap_ret,
  input  logic          irq_ack_in,
  input  logic [SW-1:0] irq_stat_in,
  output logic          in_trap,
  output logic          vec_load,
  output logic [AW-1:0] vec_addr,
  output logic [AW-1:0] pi_out,
  output logic          ack_out,
  output logic [SW-1:0] stat_out
);
  logic user_r;
  logic in_trap_n, user_n;
  logic [AW-1:0] ret_addr;

  assign ret_addr = insn_two_cyc ? pc_next : pc_next + AW'(1);

  always_comb begin
    in_trap_n = in_trap;
    user_n    = user_r;
    if (take) begin
      in_trap_n = 1'b1;
      user_n    = (take_src == SRC_USER);
    end else if (trap_ret) begin
      in_trap_n = 1'b0;
      user_n    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_trap  <= 1'b0;
      user_r   <= 1'b0;
      vec_load <= 1'b0;
      vec_addr <= '0;
      pi_out   <= '0;
      ack_out  <= 1'b0;
      stat_out <= '0;
    end else begin
      in_trap  <= in_trap_n;
      user_r   <= user_n;
      vec_load <= take;
      if (take) begin
        vec_addr <= (take_src == SRC_USER) ? USER_VEC : DBG_VEC;
        pi_out   <= ret_addr;
      end
      ack_out  <= user_n ? 1'b1 : irq_ack_in;
      stat_out <= user_n ? USER_CODE : irq_stat_in;
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            SW          = 4,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] USER_VEC    = 'h46,
  parameter logic [AW-1:0] DBG_VEC     = 'h02,
  parameter logic [SW-1:0] USER_CODE   = 'hB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trap_pin,
  input  logic          dbg_req,
  input  logic          insn_done,
  input  logic          insn_two_cyc,
  input  logic [AW-1:0] pc_next,
  input  logic          trap_ret,
  input  logic          irq_ack_in,
  input  logic [SW-1:0] irq_stat_in,
  output logic          vec_load,
  output logic [AW-1:0] vec_addr,
  output logic [AW-1:0] pi_out,
  output logic          ack_out,
  output logic [SW-1:0] stat_out
);
  logic      user_rise;
  logic      take;
  trap_src_e take_src;
  logic      in_trap;

  trap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(trap_pin), .rise(user_rise)
  );

  trap_arb u_arb (
    .clk(clk), .rst(rst), .user_rise(user_rise), .dbg_req(dbg_req),
    .insn_done(insn_done), .in_trap(in_trap),
    .take(take), .take_src(take_src)
  );

  trap_ctx #(
    .AW(AW), .SW(SW), .USER_VEC(USER_VEC), .DBG_VEC(DBG_VEC), .USER_CODE(USER_CODE)
  ) u_ctx (
    .clk(clk), .rst(rst), .take(take), .take_src(take_src),
    .insn_two_cyc(insn_two_cyc), .pc_next(pc_next), .trap_ret(trap_ret),
    .irq_ack_in(irq_ack_in), .irq_stat_in(irq_stat_in),
    .in_trap(in_trap), .vec_load(vec_load), .vec_addr(vec_addr),
    .pi_out(pi_out), .ack_out(ack_out), .stat_out(stat_out)
  );
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int            AW        = 16,
  parameter int            SW        = 4,
  parameter logic [AW-1:0] USER_VEC  = 'h46,
  parameter logic [AW-1:0] DBG_VEC   = 'h02,
  parameter logic [SW-1:0] USER_CODE = 'hB
) (
  input logic          clk,
  input logic          rst,
  input logic          insn_done,
  input logic          insn_two_cyc,
  input logic [AW-1:0] pc_next,
  input logic          irq_ack_in,
  input logic [SW-1:0] irq_stat_in,
  input logic          in_trap,
  input logic          vec_load,
  input logic [AW-1:0] vec_addr,
  input logic [AW-1:0] pi_out,
  input logic          ack_out,
  input logic [SW-1:0] stat_out
);
  // R3
  wait_insn_chk: assert property (@(posedge clk) disable iff (rst)
    vec_load |-> $past(insn_done));

  // R7
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    in_trap |=> !vec_load);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_load |=> !vec_load);

  // R5
  ret_addr_chk: assert property (@(posedge clk) disable iff (rst)
    vec_load |-> pi_out == ($past(insn_two_cyc) ? $past(pc_next) : $past(pc_next) + AW'(1)));

  // R5
  pi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vec_load && !$past(rst) |-> $stable(pi_out));

  // R4
  user_pins_chk: assert property (@(posedge clk) disable iff (rst)
    vec_load && vec_addr == USER_VEC |-> ack_out && stat_out == USER_CODE);

  // R9
  dbg_pins_chk: assert property (@(posedge clk) disable iff (rst)
    vec_load && vec_addr == DBG_VEC |-> ack_out == $past(irq_ack_in) && stat_out == $past(irq_stat_in));

  // R9
  vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
    vec_load |-> (vec_addr == USER_VEC || vec_addr == DBG_VEC));
endmodule

bind trap_seq trap_seq_chk #(
  .AW(AW), .SW(SW), .USER_VEC(USER_VEC), .DBG_VEC(DBG_VEC), .USER_CODE(USER_CODE)
) u_chk (
  .clk(clk), .rst(rst), .insn_done(insn_done), .insn_two_cyc(insn_two_cyc),
  .pc_next(pc_next), .irq_ack_in(irq_ack_in), .irq_stat_in(irq_stat_in),
  .in_trap(in_trap), .vec_load(vec_load), .vec_addr(vec_addr),
  .pi_out(pi_out), .ack_out(ack_out), .stat_out(stat_out)
);

// File: tb/trap_seq_test.sv
module trap_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int SW = 4;
  localparam int UVEC = 'h46;
  localparam int DVEC = 'h02;
  localparam int UCODE = 'hB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_pin = 1'b0, dbg_req = 1'b0, insn_done = 1'b0, insn_two_cyc = 1'b0;
  logic [AW-1:0] pc_next = '0;
  logic trap_ret = 1'b0, irq_ack_in = 1'b0;
  logic [SW-1:0] irq_stat_in = '0;
  logic vec_load, ack_out;
  logic [AW-1:0] vec_addr, pi_out;
  logic [SW-1:0] stat_out;

  trap_seq uut (
    .clk(clk), .rst(rst), .trap_pin(trap_pin), .dbg_req(dbg_req),
    .insn_done(insn_done), .insn_two_cyc(insn_two_cyc), .pc_next(pc_next),
    .trap_ret(trap_ret), .irq_ack_in(irq_ack_in), .irq_stat_in(irq_stat_in),
    .vec_load(vec_load), .vec_addr(vec_addr), .pi_out(pi_out),
    .ack_out(ack_out), .stat_out(stat_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit started = 0;

  // behavioural reference state
  int pin_hist[3];
  int m_dq, m_up, m_dp, m_busy, m_user;
  int m_vl, m_va, m_pi, m_ack, m_st;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int u_evt, d_evt;
    started <= 1;
    if (rst) begin
      foreach (pin_hist[i]) pin_hist[i] = 0;
      m_dq = 0; m_up = 0; m_dp = 0; m_busy = 0; m_user = 0;
      m_vl = 0; m_va = 0; m_pi = 0; m_ack = 0; m_st = 0;
    end else begin
      u_evt = (pin_hist[1] == 1 && pin_hist[2] == 0) ? 1 : 0;
      pin_hist[2] = pin_hist[1];
      pin_hist[1] = pin_hist[0];
      pin_hist[0] = trap_pin;
      d_evt = (dbg_req && m_dq == 0) ? 1 : 0;
      m_dq = dbg_req;
      m_vl = 0;
      if (m_busy == 0) begin
        m_up = m_up | u_evt;
        m_dp = m_dp | d_evt;
        if (insn_done && (m_up || m_dp)) begin
          m_vl = 1;
          m_va = m_up ? UVEC : DVEC;
          m_pi = insn_two_cyc ? pc_next : (pc_next + 1) % (1 << AW);
          m_busy = 1;
          m_user = m_up;
          m_up = 0; m_dp = 0;
        end
      end else if (trap_ret) begin
        m_busy = 0; m_user = 0;
      end
      m_ack = (m_busy && m_user) ? 1 : irq_ack_in;
      m_st  = (m_busy && m_user) ? UCODE : irq_stat_in;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk({cur_req, " vec_load"}, vec_load, m_vl);
      chk({cur_req, " vec_addr"}, vec_addr, m_va);
      chk({cur_req, " pi_out"}, pi_out, m_pi);
      chk({cur_req, " ack_out"}, ack_out, m_ack);
      chk({cur_req, " stat_out"}, stat_out, m_st);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ret();
    trap_ret = 1; tick(); trap_ret = 0; tick();
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    cur_req = "R1";
    chk("R1 vec_load in reset", vec_load, 0);
    chk("R1 pi_out in reset", pi_out, 0);
    rst = 0;
    tick();
    chk("R1 ack_out after reset", ack_out, 0);
    chk("R1 stat_out after reset", stat_out, 0);

    // R2 / R4: held pin, exact latency, single trap
    cur_req = "R2";
    insn_done = 1; insn_two_cyc = 1; pc_next = 16'h0010;
    trap_pin = 1;
    tick(); chk("R2 no vector after k", vec_load, 0);
    tick(); chk("R2 no vector after k+1", vec_load, 0);
    tick(); chk("R2 vector after k+2", vec_load, 1);
    chk("R4 user vector", vec_addr, UVEC);
    chk("R4 ack driven", ack_out, 1);
    chk("R4 status code", stat_out, UCODE);
    tick(); chk("R2 single pulse", vec_load, 0);
    cur_req = "R8";
    do_ret();
    tick(6); chk("R2 held pin no second trap", vec_load, 0);
    trap_pin = 0; tick(3);

    // R3: wait for instruction completion
    cur_req = "R3";
    insn_done = 0; insn_two_cyc = 1; pc_next = 16'h0120;
    trap_pin = 1; tick(); trap_pin = 0;
    tick(8); chk("R3 held off while insn busy", vec_load, 0);
    insn_done = 1; tick();
    chk("R3 taken at completion", vec_load, 1);
    chk("R5 two-cycle return address", pi_out, 16'h0120);
    cur_req = "R8"; do_ret();

    // R5: one-cycle instruction, including wraparound
    cur_req = "R5";
    insn_two_cyc = 0; pc_next = 16'h0200;
    trap_pin = 1; tick(3); trap_pin = 0;
    chk("R5 one-cycle return address", pi_out, 16'h0201);
    do_ret();
    pc_next = 16'hFFFF;
    trap_pin = 1; tick(3); trap_pin = 0;
    chk("R5 wraparound return address", pi_out, 16'h0000);
    do_ret();

    // R6: trap during interrupt service overwrites return address
    cur_req = "R6";
    irq_ack_in = 1; irq_stat_in = 4'h5; tick(2);
    chk("R11 ack follows irq", ack_out, 1);
    chk("R11 status follows irq", stat_out, 5);
    insn_two_cyc = 1; pc_next = 16'h0333;
    trap_pin = 1; tick(3); trap_pin = 0;
    chk("R6 vector during isr", vec_load, 1);
    chk("R6 pi overwritten", pi_out, 16'h0333);
    chk("R6 status overridden", stat_out, UCODE);

    // R7: nested requests discarded
    cur_req = "R7";
    pc_next = 16'h0777;
    tick(2);
    trap_pin = 1; tick(4); trap_pin = 0;
    dbg_req = 1; tick(); dbg_req = 0; tick(3);
    chk("R7 no nested vector", vec_load, 0);
    chk("R7 pi unchanged", pi_out, 16'h0333);
    cur_req = "R8"; do_ret();
    tick(5);
    chk("R7 nothing pending after return", vec_load, 0);
    chk("R8 status back to irq", stat_out, 5);
    trap_ret = 1; tick(); trap_ret = 0; tick();
    chk("R8 stray return harmless", vec_load, 0);

    // R9: debug trap keeps pins
    cur_req = "R9";
    irq_ack_in = 1; irq_stat_in = 4'h3; pc_next = 16'h0444;
    dbg_req = 1; tick();
    chk("R9 debug vector", vec_load, 1);
    chk("R9 debug address", vec_addr, DVEC);
    chk("R9 ack untouched", ack_out, 1);
    chk("R9 status untouched", stat_out, 3);
    irq_ack_in = 0; irq_stat_in = 4'h7; tick(2);
    cur_req = "R11";
    chk("R11 pins follow irq in debug trap", stat_out, 7);
    chk("R11 ack follows irq in debug trap", ack_out, 0);
    dbg_req = 0; do_ret();

    // R10: both pending
    cur_req = "R10";
    insn_done = 0; pc_next = 16'h0555;
    trap_pin = 1; dbg_req = 1; tick(); dbg_req = 0; tick(4);
    insn_done = 1; tick();
    chk("R10 user wins", vec_addr, UVEC);
    chk("R10 vector taken", vec_load, 1);
    trap_pin = 0;
    do_ret(); tick(4);
    chk("R10 debug dropped", vec_load, 0);

    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule